// File: doc/BRIEF.md
# Power Supervisor Reset Combiner

This block turns the digital outputs of three supply comparators into the chip's active-low power-on reset and a pair of low-voltage warnings. One comparator watches the core supply near 1.8 V and is the only one that can pull the chip back into reset. A second comparator watches the core supply near 2.2 V. The third watches the IO supply near 2.7 V. Each comparator flag is 1 when its supply is above its threshold. Each flag first passes through a two-stage synchronizer.

When power comes up, reset is held until the core power-on comparator and both low-voltage comparators report a good supply. Once reset is released, a sag on either low-voltage comparator does not reset the chip. It raises a sticky interrupt flag instead, so software has time for an orderly shutdown before the core supply falls far enough to trip the power-on comparator. The low-voltage inputs are oversampled. A level is reported only after a fixed number of consecutive samples agree, which rejects noise on the comparator outputs.

Top module: `pwr_rst_combiner`

## Requirements
- R1: While rst_ni is low, por_no is 0, and lv_status_o, lv_flag_o and irq_o are all 0.
- R2: por_no goes to 1 only after core_por_ok_i, core_lv_ok_i and io_lv_ok_i have all been 1 long enough to pass the synchronizer and the filter. With any of the three held at 0, por_no stays 0.
- R3: Once por_no is 1, activity on core_lv_ok_i or io_lv_ok_i alone never returns it to 0.
- R4: With por_no at 1, a 0 on core_por_ok_i drives por_no to 0 on the third rising clock edge after the input changes. After two edges it is still 1.
- R5: lv_status_o bit 0 follows core_lv_ok_i and bit 1 follows io_lv_ok_i. A status bit takes a new level only after 4 consecutive samples of that level. The first change appears on the sixth rising edge after the input changes. Pulses shorter than 4 cycles are ignored.
- R6: lv_flag_o[i] sets when lv_status_o[i] falls from 1 to 0 while por_no is 1.
- R7: A set flag stays set until a cycle in which irq_clr_i has a 1 in its bit position. A clear strobe on one bit leaves the other flag unchanged. If a set and a clear arrive in the same cycle, the set wins.
- R8: irq_o is 1 exactly when some bit i has both lv_flag_o[i] and irq_en_i[i] at 1.
- R9: While por_no is 0, both flags read 0, and low-voltage activity cannot set them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the combiner logic |
| core_por_ok_i | input | 1 | Core power-on comparator, 1 = core above about 1.8 V |
| core_lv_ok_i | input | 1 | Core low-voltage comparator, 1 = core above about 2.2 V |
| io_lv_ok_i | input | 1 | IO low-voltage comparator, 1 = IO above about 2.7 V |
| irq_en_i | input | 2 | Interrupt enable per flag (bit 0 core, bit 1 IO) |
| irq_clr_i | input | 2 | Write-one-to-clear strobes for the flags |
| por_no | output | 1 | Power-on reset, active low |
| irq_o | output | 1 | Low-voltage interrupt request |
| lv_status_o | output | 2 | Filtered low-voltage status, 1 = supply good |
| lv_flag_o | output | 2 | Sticky low-voltage interrupt flags |

## Verification
The assertions assume two things:
- The comparator inputs are arbitrary levels that reach the logic only through the synchronizer.
- irq_clr_i is a level sampled on every edge.

The stimulus respects both assumptions. It changes every input on the falling clock edge and holds each level for a whole number of cycles. This makes the pulse widths seen by the filter exact, so the width sweep checks the 4-sample threshold on both sides. The release sweep restarts from reset for every one of the eight comparator combinations. That way, a release can never carry over from an earlier combination.

// File: rtl/pwr_rst_pkg.sv
package pwr_rst_pkg;
  localparam int unsigned NUM_LV = 2;
  localparam int unsigned LV_CORE = 0;
  localparam int unsigned LV_IO   = 1;
  localparam int unsigned NUM_SENSE = NUM_LV + 1;
endpackage

// File: rtl/prc_sync.sv
module prc_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '{default: '0};
    end else begin
      stg_q[0] <= d_i;
      for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/prc_lv_filter.sv
module prc_lv_filter #(
  parameter int unsigned DEPTH = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic smp_i,
  output logic stat_o
);
  localparam int unsigned HIST_W = DEPTH - 1;

  logic [HIST_W-1:0] hist_q;
  logic [DEPTH-1:0]  window;
  logic              stat_q;

  assign window = {hist_q, smp_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      stat_q <= 1'b0;
    end else begin
      hist_q <= window[HIST_W-1:0];
      if (&window)       stat_q <= 1'b1;
      else if (~|window) stat_q <= 1'b0;
    end
  end

  assign stat_o = stat_q;

  // R5
  rise_needs_good_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_q) |-> $past(smp_i));
  // R5
  fall_needs_bad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(stat_q) |-> !$past(smp_i));
endmodule

// File: rtl/prc_por_ctrl.sv
module prc_por_ctrl #(
  parameter int unsigned NUM_LV = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              core_ok_i,
  input  logic [NUM_LV-1:0] lv_ok_i,
  output logic              por_rel_o
);
  logic por_rel_q;

  // release needs every sensor; re-entry watches only the core POR sensor
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          por_rel_q <= 1'b0;
    else if (!core_ok_i)                  por_rel_q <= 1'b0;
    else if (!por_rel_q && (&lv_ok_i))    por_rel_q <= 1'b1;
  end

  assign por_rel_o = por_rel_q;

  // R2
  release_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!por_rel_q && !(core_ok_i && (&lv_ok_i))) |=> !por_rel_q);
  // R3
  hold_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (por_rel_q && core_ok_i) |=> por_rel_q);
  // R4
  core_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !core_ok_i |=> !por_rel_q);
endmodule

// File: rtl/prc_irq_flags.sv
module prc_irq_flags #(
  parameter int unsigned NUM_LV = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_LV-1:0] stat_i,
  input  logic              por_rel_i,
  input  logic [NUM_LV-1:0] clr_i,
  input  logic [NUM_LV-1:0] en_i,
  output logic [NUM_LV-1:0] flag_o,
  output logic              irq_o
);
  logic [NUM_LV-1:0] stat_d_q;
  logic [NUM_LV-1:0] flag_q;
  logic [NUM_LV-1:0] set;

  assign set = stat_d_q & ~stat_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_d_q <= '0;
      flag_q   <= '0;
    end else begin
      stat_d_q <= stat_i;
      if (!por_rel_i) flag_q <= '0;
      else            flag_q <= (flag_q & ~clr_i) | set;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = |(flag_q & en_i);

  // R9
  held_in_por_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !por_rel_i |=> (flag_q == '0));

  for (genvar i = 0; i < NUM_LV; i++) begin : g_chk
    // R7
    sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q[i] && !clr_i[i] && por_rel_i) |=> flag_q[i]);
    // R6
    set_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (por_rel_i && stat_d_q[i] && !stat_i[i]) |=> flag_q[i]);
  end
endmodule

// File: rtl/pwr_rst_combiner.sv
module pwr_rst_combiner
  import pwr_rst_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_DEPTH  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              core_por_ok_i,
  input  logic              core_lv_ok_i,
  input  logic              io_lv_ok_i,
  input  logic [NUM_LV-1:0] irq_en_i,
  input  logic [NUM_LV-1:0] irq_clr_i,
  output logic              por_no,
  output logic              irq_o,
  output logic [NUM_LV-1:0] lv_status_o,
  output logic [NUM_LV-1:0] lv_flag_o
);
  logic [NUM_SENSE-1:0] sense_raw;
  logic [NUM_SENSE-1:0] sense_sync;
  logic [NUM_LV-1:0]    lv_filt;
  logic                 por_rel;

  assign sense_raw = {io_lv_ok_i, core_lv_ok_i, core_por_ok_i};

  prc_sync #(.WIDTH(NUM_SENSE), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sense_raw),
    .q_o   (sense_sync)
  );

  for (genvar i = 0; i < NUM_LV; i++) begin : g_filt
    prc_lv_filter #(.DEPTH(FILT_DEPTH)) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .smp_i (sense_sync[i+1]),
      .stat_o(lv_filt[i])
    );
  end

  prc_por_ctrl #(.NUM_LV(NUM_LV)) u_por (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .core_ok_i(sense_sync[0]),
    .lv_ok_i  (lv_filt),
    .por_rel_o(por_rel)
  );

  prc_irq_flags #(.NUM_LV(NUM_LV)) u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .stat_i   (lv_filt),
    .por_rel_i(por_rel),
    .clr_i    (irq_clr_i),
    .en_i     (irq_en_i),
    .flag_o   (lv_flag_o),
    .irq_o    (irq_o)
  );

  assign por_no      = por_rel;
  assign lv_status_o = lv_filt;

  // R1
  reset_state_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!por_no && lv_flag_o == '0 && !irq_o));
endmodule

// File: tb/pwr_rst_combiner_bench.sv
module pwr_rst_combiner_bench;
  localparam time CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       core_por_ok = 1'b0, core_lv_ok = 1'b0, io_lv_ok = 1'b0;
  logic [1:0] irq_en = 2'b00, irq_clr = 2'b00;
  logic       por_no, irq;
  logic [1:0] lv_status, lv_flag;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_rst_combiner u_pwr_rst_combiner (
    .clk_i(clk), .rst_ni(rst_ni),
    .core_por_ok_i(core_por_ok), .core_lv_ok_i(core_lv_ok), .io_lv_ok_i(io_lv_ok),
    .irq_en_i(irq_en), .irq_clr_i(irq_clr),
    .por_no(por_no), .irq_o(irq), .lv_status_o(lv_status), .lv_flag_o(lv_flag)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // n rising edges, then sample at the falling edge
  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    edges(2);
    rst_ni = 1'b1;
  endtask

  task automatic pulse_clr(input logic [1:0] m);
    irq_clr = m;
    edges(1);
    irq_clr = 2'b00;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R1 reset state with all sensors good
    core_por_ok = 1; core_lv_ok = 1; io_lv_ok = 1;
    edges(3);
    check("R1 por_no", por_no, 0);
    check("R1 flags", lv_flag, 0);
    check("R1 irq", irq, 0);
    check("R1 status", lv_status, 0);

    // R2 exhaustive release sweep
    for (int c = 0; c < 8; c++) begin
      core_por_ok = c[0]; core_lv_ok = c[1]; io_lv_ok = c[2];
      do_reset();
      edges(15);
      check("R2 release", por_no, (c == 7) ? 1 : 0);
    end

    // R5 exact latency of core LV status fall
    @(negedge clk);
    core_lv_ok = 1'b0;
    edges(5);
    check("R5 before 6th edge", lv_status[0], 1);
    edges(1);
    check("R5 at 6th edge", lv_status[0], 0);
    edges(3);
    check("R6 core flag", lv_flag, 2'b01);
    check("R3 por held", por_no, 1);
    // R8 enable sweep
    for (int e = 0; e < 4; e++) begin
      irq_en = e[1:0];
      edges(0);
      #1;
      check("R8 irq", irq, ((e & 1) != 0) ? 1 : 0);
    end
    @(negedge clk);
    core_lv_ok = 1'b1;
    edges(10);
    check("R7 sticky", lv_flag, 2'b01);
    check("R5 status back", lv_status, 2'b11);
    io_lv_ok = 1'b0;
    edges(10);
    check("R6 io flag", lv_flag, 2'b11);
    check("R3 por held", por_no, 1);
    irq_en = 2'b10;
    #1;
    check("R8 irq io", irq, 1);
    io_lv_ok = 1'b1;
    @(negedge clk);
    pulse_clr(2'b01);
    check("R7 clr bit0", lv_flag, 2'b10);
    pulse_clr(2'b10);
    check("R7 clr bit1", lv_flag, 2'b00);
    check("R8 irq off", irq, 0);
    edges(10);

    // R5 pulse width sweep on IO sensor
    for (int w = 1; w <= 6; w++) begin
      io_lv_ok = 1'b0;
      edges(w);
      io_lv_ok = 1'b1;
      edges(12);
      check("R5 width flag", lv_flag[1], (w >= 4) ? 1 : 0);
      check("R5 width status", lv_status[1], 1);
      check("R3 width por", por_no, 1);
      pulse_clr(2'b11);
    end

    // R4 and R9: core POR drop with flag pending
    io_lv_ok = 1'b0;
    edges(10);
    check("R6 pre drop", lv_flag, 2'b10);
    core_por_ok = 1'b0;
    edges(2);
    check("R4 after 2 edges", por_no, 1);
    edges(1);
    check("R4 after 3 edges", por_no, 0);
    edges(1);
    check("R9 flags cleared", lv_flag, 2'b00);
    io_lv_ok = 1'b1;
    edges(10);
    core_lv_ok = 1'b0;
    edges(10);
    check("R9 no set in por", lv_flag, 2'b00);
    check("R9 por still", por_no, 0);
    core_lv_ok = 1'b1;
    core_por_ok = 1'b1;
    edges(15);
    check("R2 re-release", por_no, 1);
    check("R9 clean release", lv_flag, 2'b00);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule